// File: doc/BRIEF.md
# External 16-bit Bus Cycle Sequencer

This block turns internal access requests into cycles on a 16-bit external bus. A request of 8, 16 or 32 bits (operand or fetch), or a 128-bit instruction line read, is accepted while the sequencer is idle. Wide accesses are broken into 16-bit beats. Each beat has one address-phase cycle with an active-low start strobe, then a data phase that lasts until the ready input is seen high. A 32-bit word goes upper halfword first. A 128-bit line starts at the requested halfword and wraps inside its 16-byte line. An active-low burst marker covers the whole run of beats.

The internal side gets back a one-cycle done pulse. For reads it also gets the assembled read data, with halfwords placed in address order. Requests flagged as local (an on-chip target) finish with a done pulse and never touch the bus. A hold request is granted only between whole accesses. All bus outputs float from the cycle after the grant until the cycle after it is withdrawn. The requester presents a request with `req_valid` while no access is in progress and waits for `done`.

Top module: `ext_bus_seq`

## Requirements
- R1: After reset `done` and `hold_ack` are 0, and `bus_bs_n`, `bus_burst_n`, `bus_bch_n`, `bus_bcl_n` and `bus_rd_wr_n` are 1.
- R2: A request accepted at a clock edge gives `bus_bs_n` low for exactly the next cycle (address phase). The following cycles form the data phase, with `bus_bs_n` high and address and strobes held, until a cycle in which `bus_rdy` is 1. The next beat's address phase, or `done`, comes in the cycle after that. `bus_rdy` is ignored during an address phase.
- R3: A 32-bit access (`req_size`=2) uses two beats at the word-aligned halfword addresses. `bus_addr[0]` is 0 on the first beat and 1 on the second. The first beat carries bits 31:16 of the word and the second bits 15:0, for both read data and write data.
- R4: A 128-bit access (`req_size`=3) uses eight beats, always read (`bus_rd_wr_n`=1). It starts at halfword `req_addr[3:1]` and steps by one modulo 8 inside the 16-byte line. The halfword at line offset j is returned in `rd_data[127-16j -: 16]`.
- R5: For 32-bit and 128-bit accesses `bus_burst_n` is low from the first address phase through the last data phase, and it rises in the cycle where `done` is 1. For 8-bit and 16-bit accesses it stays high.
- R6: During every cycle of a read beat both `bus_bch_n` and `bus_bcl_n` are low.
- R7: During a write beat only the enabled byte strobes are low, and `bus_dout` carries the write halfword. `bus_bch_n` covers bus bits 15:8 (even byte) and `bus_bcl_n` covers bits 7:0. For 16-bit writes `req_be[1]`/`req_be[0]` select high/low. For 32-bit writes `req_be[3:2]` apply to the first beat and `req_be[1:0]` to the second. For 8-bit writes `req_addr[0]`=0 selects high and 1 selects low, with data `req_wdata[15:0]`.
- R8: During a beat `bus_st` is 0 for a fetch and 1 for an operand access, and `bus_sid` is 1 for I/O space and 0 for user space.
- R9: A local request gives `done` in the cycle after acceptance. `bus_bs_n` stays high and `rd_data` is unchanged.
- R10: `hold_ack` rises only in the cycle after `hold_req` is sampled while no access is in progress, never between beats. It falls in the cycle after `hold_req` is sampled low. Bus outputs float from the cycle after `hold_ack` rises until the cycle after it falls, and no request is accepted during any of that time.
- R11: 8-bit and 16-bit accesses use a single beat at halfword `req_addr[AW-1:1]`. A read returns the halfword in `rd_data[15:0]` with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present (taken when idle) |
| req_addr | input | AW | Byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 line |
| req_write | input | 1 | 1 write, 0 read |
| req_fetch | input | 1 | 1 instruction fetch, 0 operand |
| req_io | input | 1 | 1 I/O space, 0 user space |
| req_local | input | 1 | Target is on-chip, no bus cycle |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables for halfword and word writes |
| rd_data | output | 128 | Assembled read data |
| done | output | 1 | One-cycle completion pulse |
| bus_addr | output | AW-1 | Halfword address, tri-state |
| bus_bs_n | output | 1 | Beat start strobe, active low, tri-state |
| bus_bch_n | output | 1 | Even-byte strobe, active low, tri-state |
| bus_bcl_n | output | 1 | Odd-byte strobe, active low, tri-state |
| bus_rd_wr_n | output | 1 | 1 read, 0 write, tri-state |
| bus_st | output | 1 | 0 fetch, 1 operand, tri-state |
| bus_sid | output | 1 | 0 user, 1 I/O space, tri-state |
| bus_burst_n | output | 1 | Multi-beat marker, active low, tri-state |
| bus_dout | output | 16 | Write data, driven only during write beats |
| bus_din | input | 16 | Read data |
| bus_rdy | input | 1 | Data-phase ready |
| hold_req | input | 1 | External request to release the bus |
| hold_ack | output | 1 | Bus release granted |

## Verification
The assertions assume that `req_valid` is offered only while no access is in progress, and that 128-bit requests come with `req_fetch` set. They also assume `bus_rdy` is a clean level sampled only in data phases. The stimulus presents each request for exactly one cycle when the block is idle and waits for `done` before the next. It toggles `bus_rdy` high during address phases to show that it is ignored there. Hold is raised both while idle and in the middle of a line read, and released only after it has been granted.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

  localparam int HW_BITS   = 16;
  localparam int LINE_HW   = 8;
  localparam int LINE_BITS = HW_BITS * LINE_HW;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_LINE = 2'd3
  } xfer_size_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } seq_state_t;

  // number of 16-bit beats an access needs
  function automatic logic [3:0] beat_count(xfer_size_t s);
    case (s)
      SZ_WORD: return 4'd2;
      SZ_LINE: return 4'd8;
      default: return 4'd1;
    endcase
  endfunction

  // halfword slot inside the 16-byte line for beat k
  function automatic logic [2:0] beat_slot(xfer_size_t s, logic [2:0] start, logic [2:0] k);
    case (s)
      SZ_LINE: return start + k;
      SZ_WORD: return {start[2:1], k[0]};
      default: return start;
    endcase
  endfunction

  // active-high byte enables {even, odd} of a write beat
  function automatic logic [1:0] wr_lanes(xfer_size_t s, logic a0, logic [3:0] be, logic k0);
    case (s)
      SZ_BYTE: return a0 ? 2'b01 : 2'b10;
      SZ_HALF: return be[1:0];
      SZ_WORD: return k0 ? be[1:0] : be[3:2];
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [15:0] wr_half(xfer_size_t s, logic [31:0] wd, logic k0);
    if (s == SZ_WORD && !k0) return wd[31:16];
    return wd[15:0];
  endfunction

  // read-data lane (16-bit unit, lane 0 = bits 15:0) filled by a beat
  function automatic logic [2:0] rd_lane(xfer_size_t s, logic [2:0] slot);
    case (s)
      SZ_LINE: return ~slot;
      SZ_WORD: return {2'b00, ~slot[0]};
      default: return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/ebs_beat_gen.sv
module ebs_beat_gen
  import ebs_pkg::*;
#(
  parameter int AW = 32
) (
  input  xfer_size_t      size,
  input  logic [AW-1:0]   base_addr,
  input  logic [2:0]      beat_idx,
  input  logic [3:0]      be,
  input  logic [31:0]     wdata,
  output logic [AW-2:0]   hw_addr,
  output logic [2:0]      slot,
  output logic            en_hi,
  output logic            en_lo,
  output logic [15:0]     wr_data,
  output logic            last
);

  logic [3:0] nbeats;
  logic [1:0] lanes;

  always_comb begin
    slot    = beat_slot(size, base_addr[3:1], beat_idx);
    hw_addr = {base_addr[AW-1:4], slot};
    lanes   = wr_lanes(size, base_addr[0], be, beat_idx[0]);
    en_hi   = lanes[1];
    en_lo   = lanes[0];
    wr_data = wr_half(size, wdata, beat_idx[0]);
    nbeats  = beat_count(size);
    last    = ({1'b0, beat_idx} == (nbeats - 4'd1));
  end

endmodule

// File: rtl/ebs_rd_pack.sv
module ebs_rd_pack
  import ebs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 capture,
  input  xfer_size_t           size,
  input  logic [2:0]           slot,
  input  logic [HW_BITS-1:0]   din,
  output logic [LINE_BITS-1:0] data
);

  logic [2:0] lane_sel;
  assign lane_sel = rd_lane(size, slot);

  for (genvar i = 0; i < LINE_HW; i++) begin : g_lane
    logic [HW_BITS-1:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  lane_q <= '0;
      else if (clear)                              lane_q <= '0;
      else if (capture && (int'(lane_sel) == i))   lane_q <= din;
    end
    assign data[i*HW_BITS +: HW_BITS] = lane_q;
  end

endmodule

// File: rtl/ebs_hold_ctl.sv
module ebs_hold_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_req,
  input  logic seq_idle,
  output logic hold_ack,
  output logic float_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_ack <= 1'b0;
      float_q  <= 1'b0;
    end else begin
      if (!hold_ack && hold_req && seq_idle) hold_ack <= 1'b1;
      else if (hold_ack && !hold_req)        hold_ack <= 1'b0;
      float_q <= hold_ack;
    end
  end

endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import ebs_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [AW-1:0]        req_addr,
  input  logic [1:0]           req_size,
  input  logic                 req_write,
  input  logic                 req_fetch,
  input  logic                 req_io,
  input  logic                 req_local,
  input  logic [31:0]          req_wdata,
  input  logic [3:0]           req_be,
  output logic [LINE_BITS-1:0] rd_data,
  output logic                 done,
  output logic [AW-2:0]        bus_addr,
  output logic                 bus_bs_n,
  output logic                 bus_bch_n,
  output logic                 bus_bcl_n,
  output logic                 bus_rd_wr_n,
  output logic                 bus_st,
  output logic                 bus_sid,
  output logic                 bus_burst_n,
  output logic [HW_BITS-1:0]   bus_dout,
  input  logic [HW_BITS-1:0]   bus_din,
  input  logic                 bus_rdy,
  input  logic                 hold_req,
  output logic                 hold_ack
);

  seq_state_t    state;
  xfer_size_t    size_q, req_sz;
  logic [AW-1:0] base_q;
  logic          wr_q, fetch_q, io_q, done_q;
  logic [3:0]    be_q;
  logic [31:0]   wd_q;
  logic [2:0]    beat_q;

  // named events for the checker
  logic          accept, accept_ext, accept_local, active, multi;
  logic          float_q, seq_idle, rd_capture;
  logic          bs_n_int, burst_n_int, bch_n_int, bcl_n_int, rw_int;

  logic [AW-2:0] hw_addr;
  logic [2:0]    slot;
  logic          en_hi, en_lo, last;
  logic [15:0]   wr_data;

  assign req_sz       = xfer_size_t'(req_size);
  assign seq_idle     = (state == ST_IDLE);
  assign accept       = seq_idle && req_valid && !hold_req && !hold_ack && !float_q;
  assign accept_ext   = accept && !req_local;
  assign accept_local = accept && req_local;
  assign active       = !seq_idle;
  assign multi        = (size_q == SZ_WORD) || (size_q == SZ_LINE);
  assign rd_capture   = (state == ST_DATA) && bus_rdy && !wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      base_q  <= '0;
      size_q  <= SZ_BYTE;
      wr_q    <= 1'b0;
      fetch_q <= 1'b0;
      io_q    <= 1'b0;
      be_q    <= '0;
      wd_q    <= '0;
      beat_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            base_q  <= req_addr;
            size_q  <= req_sz;
            wr_q    <= req_write && (req_sz != SZ_LINE);
            fetch_q <= req_fetch;
            io_q    <= req_io;
            be_q    <= req_be;
            wd_q    <= req_wdata;
            beat_q  <= '0;
            if (req_local) done_q <= 1'b1;
            else           state  <= ST_ADDR;
          end
        end
        ST_ADDR: state <= ST_DATA;
        ST_DATA: begin
          if (bus_rdy) begin
            if (last) begin
              state  <= ST_IDLE;
              done_q <= 1'b1;
            end else begin
              beat_q <= beat_q + 3'd1;
              state  <= ST_ADDR;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  ebs_beat_gen #(.AW(AW)) u_beat (
    .size      (size_q),
    .base_addr (base_q),
    .beat_idx  (beat_q),
    .be        (be_q),
    .wdata     (wd_q),
    .hw_addr   (hw_addr),
    .slot      (slot),
    .en_hi     (en_hi),
    .en_lo     (en_lo),
    .wr_data   (wr_data),
    .last      (last)
  );

  ebs_rd_pack u_pack (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept_ext),
    .capture (rd_capture),
    .size    (size_q),
    .slot    (slot),
    .din     (bus_din),
    .data    (rd_data)
  );

  ebs_hold_ctl u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_req (hold_req),
    .seq_idle (seq_idle),
    .hold_ack (hold_ack),
    .float_q  (float_q)
  );

  assign bs_n_int    = (state != ST_ADDR);
  assign burst_n_int = !(active && multi);
  assign bch_n_int   = !(active && (!wr_q || en_hi));
  assign bcl_n_int   = !(active && (!wr_q || en_lo));
  assign rw_int      = !(active && wr_q);

  assign done        = done_q;
  assign bus_addr    = float_q ? 'z   : hw_addr;
  assign bus_bs_n    = float_q ? 1'bz : bs_n_int;
  assign bus_bch_n   = float_q ? 1'bz : bch_n_int;
  assign bus_bcl_n   = float_q ? 1'bz : bcl_n_int;
  assign bus_rd_wr_n = float_q ? 1'bz : rw_int;
  assign bus_st      = float_q ? 1'bz : !fetch_q;
  assign bus_sid     = float_q ? 1'bz : io_q;
  assign bus_burst_n = float_q ? 1'bz : burst_n_int;
  assign bus_dout    = (!float_q && active && wr_q) ? wr_data : 'z;

endmodule

// File: rtl/ebs_chk.sv
module ebs_chk (
  input logic clk,
  input logic rst_n,
  input logic bs_n_int,
  input logic burst_n_int,
  input logic bch_n_int,
  input logic bcl_n_int,
  input logic rw_int,
  input logic active,
  input logic hold_ack,
  input logic float_q,
  input logic accept_local,
  input logic done_q
);

  p_addr_phase_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bs_n_int |=> bs_n_int);

  p_read_both_strobes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && rw_int) |-> (!bch_n_int && !bcl_n_int));

  p_burst_opens_on_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(burst_n_int) |-> !bs_n_int);

  p_burst_closes_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_n_int) |-> done_q);

  p_local_no_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept_local |=> (bs_n_int && done_q));

  p_ack_only_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_ack) |-> (!active && $past(!active)));

  p_float_follows_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |=> float_q);

  p_float_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_ack |=> !float_q);

  p_no_access_in_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_ack || float_q) |-> !active);

endmodule

bind ext_bus_seq ebs_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bs_n_int     (bs_n_int),
  .burst_n_int  (burst_n_int),
  .bch_n_int    (bch_n_int),
  .bcl_n_int    (bcl_n_int),
  .rw_int       (rw_int),
  .active       (active),
  .hold_ack     (hold_ack),
  .float_q      (float_q),
  .accept_local (accept_local),
  .done_q       (done_q)
);

// File: tb/test_ext_bus_seq.sv
module test_ext_bus_seq;
  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [31:0]  req_addr = '0;
  logic [1:0]   req_size = '0;
  logic         req_write = 1'b0, req_fetch = 1'b0, req_io = 1'b0, req_local = 1'b0;
  logic [31:0]  req_wdata = '0;
  logic [3:0]   req_be = '0;
  logic [127:0] rd_data;
  logic         done;
  logic [30:0]  bus_addr;
  logic         bus_bs_n, bus_bch_n, bus_bcl_n, bus_rd_wr_n, bus_st, bus_sid, bus_burst_n;
  logic [15:0]  bus_dout;
  logic [15:0]  bus_din = '0;
  logic         bus_rdy = 1'b0;
  logic         hold_req = 1'b0;
  logic         hold_ack;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #(CLK_P/2) clk = ~clk;

  ext_bus_seq #(.AW(32)) i_ext_bus_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_fetch(req_fetch),
    .req_io(req_io), .req_local(req_local), .req_wdata(req_wdata), .req_be(req_be),
    .rd_data(rd_data), .done(done), .bus_addr(bus_addr), .bus_bs_n(bus_bs_n),
    .bus_bch_n(bus_bch_n), .bus_bcl_n(bus_bcl_n), .bus_rd_wr_n(bus_rd_wr_n),
    .bus_st(bus_st), .bus_sid(bus_sid), .bus_burst_n(bus_burst_n),
    .bus_dout(bus_dout), .bus_din(bus_din), .bus_rdy(bus_rdy),
    .hold_req(hold_req), .hold_ack(hold_ack)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL R2 watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [15:0] mem_hw(logic [30:0] ha);
    return {ha[7:0], ha[15:8]} ^ 16'hC35A;
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one access; caller is at a negedge, returns at the negedge of the done cycle
  task automatic do_access(string tag, logic [31:0] a, int sz, bit wr, bit fetch,
                           bit io, logic [31:0] wd, logic [3:0] be, int waits,
                           int hold_at);
    int nb;
    bit eff_wr;
    logic [127:0] exp_rd;
    nb = (sz == 3) ? 8 : (sz == 2) ? 2 : 1;
    eff_wr = wr && (sz != 3);
    exp_rd = '0;
    req_addr = a; req_size = 2'(sz); req_write = wr; req_fetch = fetch;
    req_io = io; req_local = 1'b0; req_wdata = wd; req_be = be; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < nb; k++) begin
      logic [30:0] ha;
      int off;
      bit sh, sl;
      logic [15:0] ed;
      logic [55:0] exp_v, act_v;
      if (sz == 3) begin
        off = ((a >> 1) + k) & 7;
        ha  = 31'(((a & ~32'hF) >> 1) | 32'(off));
      end else if (sz == 2) begin
        off = k;
        ha  = 31'(((a & ~32'h3) >> 1) + 32'(k));
      end else begin
        off = 0;
        ha  = 31'(a >> 1);
      end
      if (!eff_wr) begin sh = 0; sl = 0; end
      else if (sz == 0) begin sh = a[0]; sl = !a[0]; end
      else if (sz == 1) begin sh = !be[1]; sl = !be[0]; end
      else if (k == 0) begin sh = !be[3]; sl = !be[2]; end
      else begin sh = !be[1]; sl = !be[0]; end
      ed = (sz == 2 && k == 0) ? wd[31:16] : wd[15:0];
      if (!eff_wr) ed = '0;
      if (k == hold_at) hold_req = 1'b1;
      // address phase
      exp_v = {1'b0, 1'b0, 1'b0, (sz >= 2) ? 1'b0 : 1'b1, sh, sl, !eff_wr, !fetch, io, ha, ed};
      act_v = {done, hold_ack, bus_bs_n, bus_burst_n, bus_bch_n, bus_bcl_n, bus_rd_wr_n,
               bus_st, bus_sid, bus_addr, eff_wr ? bus_dout : 16'h0};
      chk({tag, " R2 R5 R6 R7 R8 address phase"}, 128'(act_v), 128'(exp_v));
      bus_rdy = 1'b1;        // ignored in address phase
      bus_din = 16'hDEAD;
      @(negedge clk);
      for (int w = 0; w <= waits; w++) begin
        exp_v = {1'b0, 1'b0, 1'b1, (sz >= 2) ? 1'b0 : 1'b1, sh, sl, !eff_wr, !fetch, io, ha, ed};
        act_v = {done, hold_ack, bus_bs_n, bus_burst_n, bus_bch_n, bus_bcl_n, bus_rd_wr_n,
                 bus_st, bus_sid, bus_addr, eff_wr ? bus_dout : 16'h0};
        chk({tag, " R2 R5 R6 R7 R8 data phase"}, 128'(act_v), 128'(exp_v));
        bus_rdy = (w == waits);
        bus_din = mem_hw(ha);
        @(negedge clk);
      end
      bus_rdy = 1'b0;
      if (sz == 3)      exp_rd[(7 - off)*16 +: 16] = mem_hw(ha);
      else if (sz == 2) exp_rd[(1 - k)*16 +: 16]   = mem_hw(ha);
      else              exp_rd[15:0]               = mem_hw(ha);
    end
    chk({tag, " R2 R5 done cycle"},
        128'({done, hold_ack, bus_bs_n, bus_burst_n, bus_bch_n, bus_bcl_n, bus_rd_wr_n}),
        128'(7'b1011111));
    if (!eff_wr) chk({tag, " R3 R4 R11 read data"}, rd_data, exp_rd);
  endtask

  initial begin
    logic [127:0] keep;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset outputs",
        128'({done, hold_ack, bus_bs_n, bus_burst_n, bus_bch_n, bus_bcl_n, bus_rd_wr_n}),
        128'(7'b0011111));
    rst_n = 1'b1;
    @(negedge clk);

    do_access("R11 half read",        32'h0000_1002, 1, 0, 0, 0, 0, 4'h0, 0, -1);
    do_access("R11 byte read odd",    32'h0000_1107, 0, 0, 1, 0, 0, 4'h0, 1, -1);
    do_access("R7 byte write odd",    32'h0000_2001, 0, 1, 0, 0, 32'h0000_12AB, 4'h0, 0, -1);
    do_access("R7 byte write even",   32'h0000_2000, 0, 1, 0, 0, 32'h0000_CD34, 4'h0, 2, -1);
    do_access("R7 half write hi",     32'h0000_2202, 1, 1, 0, 1, 32'h0000_5A5A, 4'h2, 0, -1);
    do_access("R3 word read",         32'h0000_3006, 2, 0, 0, 0, 0, 4'h0, 2, -1);
    do_access("R3 word write",        32'h0000_3100, 2, 1, 0, 0, 32'hA1B2_C3D4, 4'h7, 1, -1);
    do_access("R3 word write lo",     32'h0000_3104, 2, 1, 0, 1, 32'h1122_3344, 4'hD, 0, -1);
    do_access("R4 line fetch mid",    32'h0000_400A, 3, 0, 1, 0, 0, 4'h0, 0, -1);
    do_access("R4 line fetch start",  32'h0000_4020, 3, 0, 1, 0, 0, 4'h0, 1, -1);
    do_access("R4 line fetch end",    32'h0000_403E, 3, 0, 1, 0, 0, 4'h0, 3, -1);
    do_access("R4 line forced read",  32'h0000_4044, 3, 1, 1, 0, 32'hFFFF_FFFF, 4'hF, 0, -1);
    do_access("R8 io operand read",   32'h0000_5008, 1, 0, 0, 1, 0, 4'h0, 0, -1);

    // R9 local request: no strobe, done next cycle, read data kept
    keep = rd_data;
    req_addr = 32'h0000_6000; req_size = 2'd2; req_write = 1'b0; req_local = 1'b1;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; req_local = 1'b0;
    chk("R9 local done no strobe", 128'({done, bus_bs_n, bus_burst_n}), 128'(3'b111));
    chk("R9 local keeps rd_data", rd_data, keep);
    @(negedge clk);
    chk("R9 local single pulse", 128'({done, bus_bs_n}), 128'(2'b01));

    // R10 hold while idle; request offered during hold is not taken
    hold_req = 1'b1;
    @(negedge clk);
    chk("R10 ack after request", 128'({hold_ack, bus_bs_n}), 128'(2'b11));
    req_addr = 32'h0000_7000; req_size = 2'd1; req_valid = 1'b1;
    @(negedge clk);
    chk("R10 held", 128'({hold_ack, done}), 128'(2'b10));
    @(negedge clk);
    chk("R10 no accept in hold", 128'({hold_ack, done}), 128'(2'b10));
    req_valid = 1'b0; hold_req = 1'b0;
    @(negedge clk);
    chk("R10 ack falls", 128'({hold_ack, done}), 128'(2'b00));
    @(negedge clk);
    chk("R10 bus driven again idle", 128'({hold_ack, done, bus_bs_n, bus_burst_n}),
        128'(4'b0011));

    // R10 hold raised inside a burst waits for the whole access
    do_access("R10 R4 hold mid burst", 32'h0000_8006, 3, 0, 1, 0, 0, 4'h0, 1, 3);
    @(negedge clk);
    chk("R10 ack after access", 128'({hold_ack, done}), 128'(2'b10));
    hold_req = 1'b0;
    @(negedge clk);
    chk("R10 release", 128'(hold_ack), 128'(1'b0));
    @(negedge clk);
    do_access("R2 after hold read", 32'h0000_9002, 2, 0, 0, 0, 0, 4'h0, 0, -1);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule